// File: doc/BRIEF.md
# VGA Sync and Blanking Generator

This block produces the raster timing for a monochrome bit-mapped display. It counts system clocks along each line and lines down each frame, and from those two positions derives four flags: a horizontal video enable, a vertical video enable, an active-low horizontal sync and an active-low vertical sync. It also produces a one-clock frame-start pulse that a video memory fetch engine uses to rewind its address counter to the top of the picture.

Each flag is held in its own register, which is set when the count reaches one programmed value and cleared when it reaches another. The decode for each flag looks one count ahead, so the registered flag changes on the same clock as the counter reaches the programmed value. The default geometry gives a 381-clock line and a 528-line frame. Within a line, 288 clocks carry picture. Within a frame, 455 lines carry picture. The syncs are shifted away from the blanking edges so that the picture sits in the middle of the screen. A pixel serializer downstream combines the two enables to decide when to shift out data.

Top module: `vga_sync_gen`

## Requirements
- R1: The line position counts 0 to LINE_CLKS-1 (default 381 clocks) and then returns to 0, so the horizontal enable rises exactly every LINE_CLKS clocks.
- R2: `h_en_o` is 1 while the line position is below H_BLANK_AT (default 288) and 0 from H_BLANK_AT to the end of the line.
- R3: `hsync_n_o` is 0 while the line position is in the range H_SYNC_ON to H_SYNC_OFF-1 (default 308 to 352) and 1 everywhere else.
- R4: `v_en_o` is 1 on lines below V_BLANK_AT (default 455) and 0 on the remaining lines of the frame.
- R5: `vsync_n_o` is 0 on lines V_SYNC_ON to V_SYNC_OFF-1 (default 486 and 487) and 1 on all other lines.
- R6: The line number advances by one only on the clock after the line position leaves LINE_CLKS-1. It returns to 0 after line FRAME_LINES-1 (default 528), so a frame lasts LINE_CLKS*FRAME_LINES clocks.
- R7: `frame_start_o` is 1 for exactly one clock: the first clock of every frame that follows a frame wrap (position 0, line 0). It stays 0 in the first frame after reset.
- R8: A synchronous active-high `rst` puts the block at position 0 of line 0. In that state both enables are 1, both syncs are 1 and `frame_start_o` is 0. Counting resumes from there on the first clock after `rst` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| h_en_o | output | 1 | Horizontal video enable (picture part of the line) |
| v_en_o | output | 1 | Vertical video enable (picture part of the frame) |
| hsync_n_o | output | 1 | Active-low horizontal sync |
| vsync_n_o | output | 1 | Active-low vertical sync |
| frame_start_o | output | 1 | One-clock pulse at the start of each new frame; rewinds the fetch address |

## Verification
The generator has no data inputs, so the patterns tried are geometries and reset points. The bench uses a shrunken geometry so that it can cover more than two full frames. Every cycle is compared with a position model, and a table of probes sits on each set and clear boundary, one clock before and one clock on. These probes tell an off-by-one decode apart from a wrong flag. A mid-line reset followed by a second run checks that counting restarts from line 0 and that no false frame pulse appears after reset. Measuring the spacing of the enable edges separates a wrong line length from a wrong blanking point.

// File: rtl/vga_sync_pkg.sv
package vga_sync_pkg;

    // Default raster geometry (system clocks per line, lines per frame)
    localparam int DEF_H_WIDTH     = 9;
    localparam int DEF_V_WIDTH     = 10;
    localparam int DEF_LINE_CLKS   = 381;
    localparam int DEF_H_BLANK_AT  = 288;
    localparam int DEF_H_SYNC_ON   = 308;
    localparam int DEF_H_SYNC_OFF  = 353;
    localparam int DEF_FRAME_LINES = 528;
    localparam int DEF_V_BLANK_AT  = 455;
    localparam int DEF_V_SYNC_ON   = 486;
    localparam int DEF_V_SYNC_OFF  = 488;

    // Per-axis flag bundle
    typedef struct packed {
        logic sync_act;   // sync pulse active (high-true internally)
        logic en;         // video enable for this axis
    } axis_flags_t;

    // Index of each flag inside an axis
    typedef enum int {
        FLAG_EN   = 0,
        FLAG_SYNC = 1
    } flag_idx_e;

    // Count that precedes position n on a ring of lim positions
    function automatic int prev_pos(input int n, input int lim);
        return (n == 0) ? lim - 1 : n - 1;
    endfunction

endpackage

// File: rtl/vga_mod_counter.sv
module vga_mod_counter #(
    parameter int WIDTH = 9,
    parameter int LIMIT = 381
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [WIDTH-1:0] cnt,
    output logic             wrap
);
    localparam logic [WIDTH-1:0] LAST = WIDTH'(LIMIT - 1);

    logic [WIDTH-1:0] cnt_q;

    assign wrap = adv && (cnt_q == LAST);
    assign cnt  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) < LIMIT);                                   // R1

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(cnt_q));                               // R6

endmodule

// File: rtl/vga_sr_flag.sv
module vga_sr_flag #(
    parameter int   WIDTH  = 9,
    parameter int   LIMIT  = 381,
    parameter int   SET_AT = 0,
    parameter int   CLR_AT = 288,
    parameter logic INIT   = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [WIDTH-1:0] cnt,
    output logic             q
);
    // Decode one count early so the registered flag moves with the counter
    localparam logic [WIDTH-1:0] SET_DEC = WIDTH'(vga_sync_pkg::prev_pos(SET_AT, LIMIT));
    localparam logic [WIDTH-1:0] CLR_DEC = WIDTH'(vga_sync_pkg::prev_pos(CLR_AT, LIMIT));

    logic q_q;
    logic hit_set, hit_clr;

    assign hit_set = adv && (cnt == SET_DEC);
    assign hit_clr = adv && (cnt == CLR_DEC);
    assign q       = q_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_q <= INIT;
        end else if (hit_set) begin
            q_q <= 1'b1;
        end else if (hit_clr) begin
            q_q <= 1'b0;
        end
    end

endmodule

// File: rtl/vga_axis.sv
module vga_axis #(
    parameter int WIDTH    = 9,
    parameter int LIMIT    = 381,
    parameter int BLANK_AT = 288,
    parameter int SYNC_ON  = 308,
    parameter int SYNC_OFF = 353
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       adv,
    output logic [WIDTH-1:0]           cnt,
    output logic                       wrap,
    output vga_sync_pkg::axis_flags_t  flags
);
    import vga_sync_pkg::*;

    localparam int NFLAGS = 2;

    logic [NFLAGS-1:0] fl;

    vga_mod_counter #(.WIDTH(WIDTH), .LIMIT(LIMIT)) ctr_i (
        .clk  (clk),
        .rst  (rst),
        .adv  (adv),
        .cnt  (cnt),
        .wrap (wrap)
    );

    for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
        localparam int   SET_V  = (i == FLAG_EN) ? 0        : SYNC_ON;
        localparam int   CLR_V  = (i == FLAG_EN) ? BLANK_AT : SYNC_OFF;
        localparam logic INIT_V = (i == FLAG_EN) ? 1'b1     : 1'b0;

        vga_sr_flag #(
            .WIDTH  (WIDTH),
            .LIMIT  (LIMIT),
            .SET_AT (SET_V),
            .CLR_AT (CLR_V),
            .INIT   (INIT_V)
        ) flag_i (
            .clk (clk),
            .rst (rst),
            .adv (adv),
            .cnt (cnt),
            .q   (fl[i])
        );
    end

    assign flags.en       = fl[FLAG_EN];
    assign flags.sync_act = fl[FLAG_SYNC];

endmodule

// File: rtl/vga_sync_gen.sv
module vga_sync_gen #(
    parameter int H_WIDTH     = vga_sync_pkg::DEF_H_WIDTH,
    parameter int V_WIDTH     = vga_sync_pkg::DEF_V_WIDTH,
    parameter int LINE_CLKS   = vga_sync_pkg::DEF_LINE_CLKS,
    parameter int H_BLANK_AT  = vga_sync_pkg::DEF_H_BLANK_AT,
    parameter int H_SYNC_ON   = vga_sync_pkg::DEF_H_SYNC_ON,
    parameter int H_SYNC_OFF  = vga_sync_pkg::DEF_H_SYNC_OFF,
    parameter int FRAME_LINES = vga_sync_pkg::DEF_FRAME_LINES,
    parameter int V_BLANK_AT  = vga_sync_pkg::DEF_V_BLANK_AT,
    parameter int V_SYNC_ON   = vga_sync_pkg::DEF_V_SYNC_ON,
    parameter int V_SYNC_OFF  = vga_sync_pkg::DEF_V_SYNC_OFF
) (
    input  logic clk,
    input  logic rst,
    output logic h_en_o,
    output logic v_en_o,
    output logic hsync_n_o,
    output logic vsync_n_o,
    output logic frame_start_o
);
    import vga_sync_pkg::*;

    logic [H_WIDTH-1:0] h_cnt;
    logic [V_WIDTH-1:0] v_cnt;
    logic               h_wrap, v_wrap;
    axis_flags_t        h_fl, v_fl;
    logic               fstart_q;

    vga_axis #(
        .WIDTH    (H_WIDTH),
        .LIMIT    (LINE_CLKS),
        .BLANK_AT (H_BLANK_AT),
        .SYNC_ON  (H_SYNC_ON),
        .SYNC_OFF (H_SYNC_OFF)
    ) h_axis_i (
        .clk   (clk),
        .rst   (rst),
        .adv   (1'b1),
        .cnt   (h_cnt),
        .wrap  (h_wrap),
        .flags (h_fl)
    );

    // Lines advance once per line, on the horizontal wrap
    vga_axis #(
        .WIDTH    (V_WIDTH),
        .LIMIT    (FRAME_LINES),
        .BLANK_AT (V_BLANK_AT),
        .SYNC_ON  (V_SYNC_ON),
        .SYNC_OFF (V_SYNC_OFF)
    ) v_axis_i (
        .clk   (clk),
        .rst   (rst),
        .adv   (h_wrap),
        .cnt   (v_cnt),
        .wrap  (v_wrap),
        .flags (v_fl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fstart_q <= 1'b0;
        end else begin
            fstart_q <= h_wrap && v_wrap;
        end
    end

    assign h_en_o        = h_fl.en;
    assign v_en_o        = v_fl.en;
    assign hsync_n_o     = ~h_fl.sync_act;
    assign vsync_n_o     = ~v_fl.sync_act;
    assign frame_start_o = fstart_q;

    AST_HEN_ZONE: assert property (@(posedge clk) disable iff (rst)
        h_en_o == (int'(h_cnt) < H_BLANK_AT));                               // R2

    AST_HSYNC_ZONE: assert property (@(posedge clk) disable iff (rst)
        hsync_n_o == !(int'(h_cnt) >= H_SYNC_ON && int'(h_cnt) < H_SYNC_OFF)); // R3

    AST_VEN_ZONE: assert property (@(posedge clk) disable iff (rst)
        v_en_o == (int'(v_cnt) < V_BLANK_AT));                               // R4

    AST_VSYNC_ZONE: assert property (@(posedge clk) disable iff (rst)
        vsync_n_o == !(int'(v_cnt) >= V_SYNC_ON && int'(v_cnt) < V_SYNC_OFF)); // R5

    AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
        (int'(h_cnt) != LINE_CLKS - 1) |=> $stable(v_cnt));                  // R6

    AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (rst)
        frame_start_o |-> (h_cnt == '0 && v_cnt == '0));                      // R7

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        frame_start_o |=> !frame_start_o);                                    // R7

    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (h_cnt == '0 && v_cnt == '0 && h_en_o && v_en_o
                        && hsync_n_o && vsync_n_o && !frame_start_o));         // R8

endmodule

// File: tb/vga_sync_gen_tb_top.sv
module vga_sync_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int L   = 40;
    localparam int HB  = 24;
    localparam int HSN = 28;
    localparam int HSF = 33;
    localparam int F   = 20;
    localparam int VB  = 14;
    localparam int VSN = 16;
    localparam int VSF = 18;
    localparam int WATCHDOG = 20000;

    // Probe table: cycle since reset release, expected {h_en,hsync_n,v_en,vsync_n,frame_start}
    typedef struct packed {
        int unsigned cyc;
        int unsigned rq;
        logic [4:0]  exp;
    } vec_t;

    localparam int NVEC = 17;
    localparam vec_t VECS [NVEC] = '{
        '{cyc: 0,    rq: 8, exp: 5'b11110},
        '{cyc: 23,   rq: 2, exp: 5'b11110},
        '{cyc: 24,   rq: 2, exp: 5'b01110},
        '{cyc: 27,   rq: 3, exp: 5'b01110},
        '{cyc: 28,   rq: 3, exp: 5'b00110},
        '{cyc: 32,   rq: 3, exp: 5'b00110},
        '{cyc: 33,   rq: 3, exp: 5'b01110},
        '{cyc: 39,   rq: 1, exp: 5'b01110},
        '{cyc: 40,   rq: 1, exp: 5'b11110},
        '{cyc: 559,  rq: 4, exp: 5'b01110},
        '{cyc: 560,  rq: 4, exp: 5'b11010},
        '{cyc: 640,  rq: 5, exp: 5'b11000},
        '{cyc: 719,  rq: 5, exp: 5'b01000},
        '{cyc: 720,  rq: 5, exp: 5'b11010},
        '{cyc: 800,  rq: 7, exp: 5'b11111},
        '{cyc: 801,  rq: 7, exp: 5'b11110},
        '{cyc: 1628, rq: 6, exp: 5'b00110}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic h_en, v_en, hsync_n, vsync_n, fstart;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    vga_sync_gen #(
        .H_WIDTH(9), .V_WIDTH(10),
        .LINE_CLKS(L), .H_BLANK_AT(HB), .H_SYNC_ON(HSN), .H_SYNC_OFF(HSF),
        .FRAME_LINES(F), .V_BLANK_AT(VB), .V_SYNC_ON(VSN), .V_SYNC_OFF(VSF)
    ) dut_i (
        .clk           (clk),
        .rst           (rst),
        .h_en_o        (h_en),
        .v_en_o        (v_en),
        .hsync_n_o     (hsync_n),
        .vsync_n_o     (vsync_n),
        .frame_start_o (fstart)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [4:0] model(input int c);
        int p, ln;
        logic [4:0] r;
        p  = c % L;
        ln = (c / L) % F;
        r[4] = (p < HB);
        r[3] = !(p >= HSN && p < HSF);
        r[2] = (ln < VB);
        r[1] = !(ln >= VSN && ln < VSF);
        r[0] = (c > 0) && (p == 0) && (ln == 0);
        return r;
    endfunction

    function automatic logic [4:0] outs();
        return {h_en, hsync_n, v_en, vsync_n, fstart};
    endfunction

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp, input int c);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %b expected %b", tag, c, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Compare every cycle with the model; the requirement blamed is the first differing field
    task automatic scan(input int ncyc);
        for (int c = 0; c < ncyc; c++) begin
            logic [4:0] a, e;
            a = outs();
            e = model(c);
            if (a[4] !== e[4] || a[3] !== e[3])
                check(a[4] !== e[4] ? "R2" : "R3", a, e, c);
            else if (a[2] !== e[2] || a[1] !== e[1])
                check(a[2] !== e[2] ? "R4" : "R5", a, e, c);
            else
                check("R7", a, e, c);
            @(negedge clk);
        end
    endtask

    int last_rise;
    int rise_gap_bad;
    int first_vfall;

    initial begin
        rise_gap_bad = 0;
        first_vfall  = -1;
        last_rise    = -1;

        // Reset held over several edges, released at a falling edge
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R8", outs(), 5'b11110, -1);
        rst = 1'b0;

        // Table walk plus per-cycle edge tracking
        begin
            int vi;
            logic prev_h, prev_v;
            vi = 0;
            prev_h = 1'b1;
            prev_v = 1'b1;
            for (int c = 0; c <= 1700; c++) begin
                if (vi < NVEC && VECS[vi].cyc == c) begin
                    check($sformatf("R%0d", VECS[vi].rq), outs(), VECS[vi].exp, c);
                    vi++;
                end
                // R1: enable rises spaced by exactly one line
                if (h_en && !prev_h) begin
                    if (last_rise >= 0 && (c - last_rise) != L) rise_gap_bad++;
                    last_rise = c;
                end
                // R6: vertical blanking first begins VB lines in
                if (!v_en && prev_v && first_vfall < 0) first_vfall = c;
                prev_h = h_en;
                prev_v = v_en;
                @(negedge clk);
            end
        end
        checks++;
        if (rise_gap_bad != 0) begin
            fails++;
            $display("FAIL R1 rise spacing: actual %0d bad gaps expected 0", rise_gap_bad);
        end
        checks++;
        if (first_vfall != VB * L) begin
            fails++;
            $display("FAIL R6 first vertical blank: actual %0d expected %0d", first_vfall, VB * L);
        end

        // R8: mid-line reset, outputs return to start state while held
        rst = 1'b1;
        @(negedge clk);
        check("R8", outs(), 5'b11110, -2);
        @(negedge clk);
        check("R8", outs(), 5'b11110, -3);
        rst = 1'b0;

        // Fresh run from line 0; R7 no pulse at cycle 0, pulse at frame wrap
        scan(2 * L * F + 5);

        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule